// File: doc/BRIEF.md
# Fault Injection Campaign Sequencer

The sequencer runs a campaign of single-bit upsets over a window of configuration-bit addresses. For each injection it chooses a target address and issues a flip command on a valid/ready command port; an external engine performs the frame modification. It then starts a functional test and waits for the test to report done and pass or fail. Depending on the campaign mode, it may issue a restore command before it decides whether to continue.

Three modes are offered. The first is a sequential walk that undoes every flip. The second is random accumulation, where the faults stay in place. The third is random accumulation in which all frames are restored after a programmed number of injections, after which accumulation begins again. The campaign ends on the first failing test, on a flip budget, or only on an abort request. A sequential walk also ends when it has used the last address of its window. A pulse on `start` latches the configuration and clears the injection counter.

Top module: `fi_campaign_seq`

## Requirements
- R1: In sequential mode (mode code 0), the flip addresses are the window's low bound, then the low bound plus 1, and so on, one step per injection.
- R2: In sequential mode, after each test completes, a single-frame restore (`cmd_restore`=1, `cmd_all`=0) is issued for the address just flipped, before any further flip.
- R3: Every flip address lies within the window from `cfg_lo` to `cfg_hi`, with both bounds inclusive. In the random modes, addresses come from a 32-bit LFSR with a nonzero seed (a zero seed is replaced), and out-of-window values are rejected.
- R4: In accumulation mode (mode code 1; code 3 behaves the same), no restore command is ever issued.
- R5: In clean-up mode (mode code 2), a restore-all command (`cmd_restore`=1, `cmd_all`=1) follows the test of every Nth injection since the last clean-up, where N is `cfg_clean_n`. A value of 0 behaves as 1.
- R6: With stop code 0, the campaign ends after the first test that reports `test_fail`=1.
- R7: With stop code 1, the campaign ends once `inj_count` reaches `cfg_flip_limit` (a limit of 0 behaves as 1), and failures are ignored. With stop code 2 (code 3 behaves the same), the campaign ends only on abort. An abort is acted on after the test in progress completes.
- R8: Exactly one `test_start` pulse follows each accepted flip. No command is issued while a test is outstanding.
- R9: A command holds `cmd_valid`, `cmd_addr`, `cmd_restore` and `cmd_all` steady until `cmd_ready` is seen.
- R10: `inj_count` clears on `start` and increments by one on each accepted flip command.
- R11: `done` rises when a stop condition fires, or in sequential mode after the `cfg_hi` address has been injected, whatever the stop code. A window with `cfg_lo` > `cfg_hi` ends at once with no injection. While `done` is high, no command or test start is issued.
- R12: After reset, `done`, `busy`, `cmd_valid` and `test_start` are 0 and `inj_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a campaign (accepted when idle or done) |
| abort | input | 1 | Request to end the running campaign |
| cfg_mode | input | 2 | 0 sequential, 1 accumulate, 2 accumulate with clean-up |
| cfg_stop | input | 2 | 0 first failure, 1 flip budget, 2 run until abort |
| cfg_lo | input | AW | Lowest address of the window |
| cfg_hi | input | AW | Highest address of the window |
| cfg_clean_n | input | CW | Injections between clean-ups |
| cfg_flip_limit | input | 32 | Flip budget for stop code 1 |
| cfg_seed | input | 32 | LFSR seed |
| cmd_valid | output | 1 | Command request |
| cmd_ready | input | 1 | Command accepted |
| cmd_restore | output | 1 | 0 flip, 1 restore |
| cmd_all | output | 1 | Restore applies to all frames |
| cmd_addr | output | AW | Bit address of the command |
| test_start | output | 1 | One-cycle test start pulse |
| test_done | input | 1 | Test finished |
| test_fail | input | 1 | Test result, valid with test_done |
| inj_count | output | 32 | Accepted flips in this campaign |
| busy | output | 1 | Campaign running |
| done | output | 1 | Campaign ended |

## Verification
The bench builds the block with a 12-bit address width and an 8-bit clean-up count. This makes windows of a few addresses cheap to walk to exhaustion, and a full 4096-address window available for abort runs. A seven-address window at offset zero makes the random reduction reject candidates often, which exercises that path. Small flip budgets and clean-up counts put the clean-up boundaries, the stop points and the zero-as-one corner cases within a few dozen injections.

// File: rtl/fi_pkg.sv
package fi_pkg;
  localparam logic [1:0] MODE_SEQ   = 2'd0;
  localparam logic [1:0] MODE_CLEAN = 2'd2;
  localparam logic [1:0] STOP_FAIL  = 2'd0;
  localparam logic [1:0] STOP_COUNT = 2'd1;
  localparam logic [31:0] LFSR_ALT_SEED = 32'h6A09_E667;
  localparam logic [31:0] LFSR_MASK     = 32'hB4BC_D35C;

  typedef enum logic [3:0] {
    S_IDLE, S_PICK, S_FLIP, S_TGO, S_TWAIT, S_RST1, S_RSTALL, S_CHECK, S_DONE
  } fi_state_e;

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    lfsr_next = s[0] ? ((s >> 1) ^ LFSR_MASK) : (s >> 1);
  endfunction
endpackage

// File: rtl/fi_loc_gen.sv
module fi_loc_gen import fi_pkg::*; #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_lo,
  input  logic [31:0]   load_seed,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          seq_sel,
  input  logic          roll,
  input  logic          advance,
  output logic [AW-1:0] loc,
  output logic          loc_ok,
  output logic          seq_last
);
  logic [AW-1:0] ptr_q;
  logic [31:0]   lfsr_q;
  logic [AW-1:0] span, mask, cand;

  function automatic logic [AW-1:0] fill_below(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    r = v;
    for (int i = 0; i < AW; i++) r = r | (r >> 1);
    return r;
  endfunction

  function automatic logic [AW-1:0] fold_bits(input logic [31:0] s);
    logic [AW-1:0] f;
    f = '0;
    for (int i = 0; i < 32; i++) f[i % AW] = f[i % AW] ^ s[i];
    return f;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      lfsr_q <= LFSR_ALT_SEED;
    end else if (load) begin
      ptr_q  <= load_lo;
      lfsr_q <= (load_seed == 32'd0) ? LFSR_ALT_SEED : load_seed;
    end else begin
      if (advance) ptr_q <= ptr_q + 1'b1;
      if (roll) lfsr_q <= lfsr_next(lfsr_q);
    end
  end

  always_comb begin
    span = hi - lo;
    mask = fill_below(span);
    cand = fold_bits(lfsr_q) & mask;
    if (seq_sel) begin
      loc    = ptr_q;
      loc_ok = 1'b1;
    end else begin
      loc    = lo + cand;
      loc_ok = (cand <= span);
    end
    seq_last = (ptr_q == hi);
  end

  assert_lfsr_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 32'd0);
endmodule

// File: rtl/fi_stop_eval.sv
module fi_stop_eval import fi_pkg::*; (
  input  logic [1:0]  stop_sel,
  input  logic        failed,
  input  logic [31:0] count,
  input  logic [31:0] limit,
  input  logic        aborted,
  input  logic        seq_sel,
  input  logic        seq_last,
  output logic        stop_now
);
  logic by_fail, by_count, by_end;
  logic [31:0] eff_limit;

  always_comb begin
    eff_limit = (limit == 32'd0) ? 32'd1 : limit;
    by_fail   = (stop_sel == STOP_FAIL) && failed;
    by_count  = (stop_sel == STOP_COUNT) && (count >= eff_limit);
    by_end    = seq_sel && seq_last;
    stop_now  = by_fail || by_count || by_end || aborted;
  end
endmodule

// File: rtl/fi_campaign_seq.sv
module fi_campaign_seq import fi_pkg::*; #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          abort,
  input  logic [1:0]    cfg_mode,
  input  logic [1:0]    cfg_stop,
  input  logic [AW-1:0] cfg_lo,
  input  logic [AW-1:0] cfg_hi,
  input  logic [CW-1:0] cfg_clean_n,
  input  logic [31:0]   cfg_flip_limit,
  input  logic [31:0]   cfg_seed,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic          cmd_restore,
  output logic          cmd_all,
  output logic [AW-1:0] cmd_addr,
  output logic          test_start,
  input  logic          test_done,
  input  logic          test_fail,
  output logic [31:0]   inj_count,
  output logic          busy,
  output logic          done
);
  fi_state_e     state_q;
  logic [1:0]    mode_q, stop_q;
  logic [AW-1:0] lo_q, hi_q, cur_addr_q, loc;
  logic [CW-1:0] clean_n_q, since_q, clean_eff;
  logic [31:0]   limit_q, inj_q;
  logic          fail_q, abort_q;
  logic          seq_sel, clean_sel, loc_ok, seq_last, stop_now;
  logic          start_go, flip_fire, roll, advance;

  assign seq_sel   = (mode_q == MODE_SEQ);
  assign clean_sel = (mode_q == MODE_CLEAN);
  assign clean_eff = (clean_n_q == '0) ? CW'(1) : clean_n_q;
  assign start_go  = start && (state_q == S_IDLE || state_q == S_DONE);
  assign flip_fire = (state_q == S_FLIP) && cmd_ready;
  assign roll      = (state_q == S_PICK) && !seq_sel;
  assign advance   = (state_q == S_CHECK) && !stop_now && seq_sel;

  fi_loc_gen #(.AW(AW)) loc_i (
    .clk(clk), .rst_n(rst_n), .load(start_go), .load_lo(cfg_lo),
    .load_seed(cfg_seed), .lo(lo_q), .hi(hi_q), .seq_sel(seq_sel),
    .roll(roll), .advance(advance), .loc(loc), .loc_ok(loc_ok),
    .seq_last(seq_last)
  );

  fi_stop_eval stop_i (
    .stop_sel(stop_q), .failed(fail_q), .count(inj_q), .limit(limit_q),
    .aborted(abort_q), .seq_sel(seq_sel), .seq_last(seq_last),
    .stop_now(stop_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      mode_q     <= '0;
      stop_q     <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      clean_n_q  <= '0;
      limit_q    <= '0;
      cur_addr_q <= '0;
      inj_q      <= '0;
      since_q    <= '0;
      fail_q     <= 1'b0;
      abort_q    <= 1'b0;
    end else if (start_go) begin
      mode_q    <= cfg_mode;
      stop_q    <= cfg_stop;
      lo_q      <= cfg_lo;
      hi_q      <= cfg_hi;
      clean_n_q <= cfg_clean_n;
      limit_q   <= cfg_flip_limit;
      inj_q     <= '0;
      since_q   <= '0;
      fail_q    <= 1'b0;
      abort_q   <= 1'b0;
      state_q   <= (cfg_lo > cfg_hi) ? S_DONE : S_PICK;
    end else begin
      if (abort && busy) abort_q <= 1'b1;
      unique case (state_q)
        S_PICK: if (loc_ok) begin
          cur_addr_q <= loc;
          state_q    <= S_FLIP;
        end
        S_FLIP: if (cmd_ready) begin
          inj_q   <= inj_q + 32'd1;
          if (clean_sel) since_q <= since_q + 1'b1;
          state_q <= S_TGO;
        end
        S_TGO:  state_q <= S_TWAIT;
        S_TWAIT: if (test_done) begin
          fail_q <= test_fail;
          if (seq_sel)                          state_q <= S_RST1;
          else if (clean_sel && since_q >= clean_eff) state_q <= S_RSTALL;
          else                                  state_q <= S_CHECK;
        end
        S_RST1: if (cmd_ready) state_q <= S_CHECK;
        S_RSTALL: if (cmd_ready) begin
          since_q <= '0;
          state_q <= S_CHECK;
        end
        S_CHECK: state_q <= stop_now ? S_DONE : S_PICK;
        default: ;
      endcase
    end
  end

  assign cmd_valid   = (state_q == S_FLIP) || (state_q == S_RST1) || (state_q == S_RSTALL);
  assign cmd_restore = (state_q == S_RST1) || (state_q == S_RSTALL);
  assign cmd_all     = (state_q == S_RSTALL);
  assign cmd_addr    = cur_addr_q;
  assign test_start  = (state_q == S_TGO);
  assign inj_count   = inj_q;
  assign busy        = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done        = (state_q == S_DONE);

  assert_flip_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_restore) |-> (cmd_addr >= lo_q && cmd_addr <= hi_q));
  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
                                   $stable(cmd_restore) && $stable(cmd_all)));
  assert_accum_no_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_restore) |-> (seq_sel || clean_sel));
  assert_quiet_during_test_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_TWAIT) |-> (!cmd_valid && !test_start));
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flip_fire |=> (inj_count == $past(inj_count) + 32'd1));
  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flip_fire && !start_go) |=> $stable(inj_count));
  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cmd_valid && !test_start && !busy));
endmodule

// File: tb/fi_campaign_seq_tb_top.sv
module fi_campaign_seq_tb_top;
  localparam int AW = 12;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0;
  logic [1:0] cfg_mode = '0, cfg_stop = '0;
  logic [AW-1:0] cfg_lo = '0, cfg_hi = '0;
  logic [CW-1:0] cfg_clean_n = '0;
  logic [31:0] cfg_flip_limit = '0, cfg_seed = 32'h1234_5678;
  logic cmd_valid, cmd_restore, cmd_all, test_start, busy, done;
  logic cmd_ready = 1'b0, test_done = 1'b0, test_fail = 1'b0;
  logic [AW-1:0] cmd_addr;
  logic [31:0] inj_count;

  int total = 0, bad = 0;
  int ev_kind [0:1023];
  int ev_addr [0:1023];
  int n_ev = 0, n_test = 0, n_fire = 0, stall_left = 0, tdelay = 0, fail_at = 0;
  bit tpend = 0, hold_seen = 0, hold_bad = 0, overlap = 0, dbl = 0;
  logic [AW-1:0] hold_addr = '0;

  always #2 clk = ~clk;

  fi_campaign_seq #(.AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .cfg_mode(cfg_mode), .cfg_stop(cfg_stop), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_clean_n(cfg_clean_n), .cfg_flip_limit(cfg_flip_limit), .cfg_seed(cfg_seed),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_restore(cmd_restore),
    .cmd_all(cmd_all), .cmd_addr(cmd_addr), .test_start(test_start),
    .test_done(test_done), .test_fail(test_fail), .inj_count(inj_count),
    .busy(busy), .done(done)
  );

  // Responder for the command port and the test port, plus event log.
  initial begin
    forever begin
      @(negedge clk);
      if (tpend && cmd_valid) overlap = 1;
      if (cmd_valid) begin
        if (!hold_seen) begin hold_addr = cmd_addr; hold_seen = 1; end
        else if (cmd_addr != hold_addr) hold_bad = 1;
        if (stall_left > 0) begin
          stall_left--;
          cmd_ready = 1'b0;
        end else begin
          cmd_ready = 1'b1;
          if (n_ev < 1024) begin
            ev_kind[n_ev] = !cmd_restore ? 0 : (cmd_all ? 2 : 1);
            ev_addr[n_ev] = int'(cmd_addr);
            n_ev++;
          end
          hold_seen = 0;
          stall_left = n_fire % 3;
          n_fire++;
        end
      end else cmd_ready = 1'b0;
      test_done = 1'b0;
      test_fail = 1'b0;
      if (tpend) begin
        if (tdelay == 0) begin
          test_done = 1'b1;
          test_fail = (fail_at != 0 && n_test == fail_at);
          tpend = 0;
        end else tdelay--;
      end
      if (test_start) begin
        if (tpend) dbl = 1;
        n_test++;
        tpend = 1;
        tdelay = n_test % 4;
        if (n_ev < 1024) begin
          ev_kind[n_ev] = 3; ev_addr[n_ev] = 0; n_ev++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_kinds(output int f, output int r1, output int ra, output int t);
    f = 0; r1 = 0; ra = 0; t = 0;
    for (int i = 0; i < n_ev; i++) begin
      if (ev_kind[i] == 0) f++;
      else if (ev_kind[i] == 1) r1++;
      else if (ev_kind[i] == 2) ra++;
      else t++;
    end
  endtask

  task automatic launch(input logic [1:0] m, input logic [1:0] s, input int lo, input int hi,
                        input int cl, input int lim, input int fa);
    @(negedge clk);
    cfg_mode = m; cfg_stop = s; cfg_lo = AW'(lo); cfg_hi = AW'(hi);
    cfg_clean_n = CW'(cl); cfg_flip_limit = lim; fail_at = fa;
    n_ev = 0; n_test = 0; overlap = 0; dbl = 0; hold_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int cyc = 0;
    while (!done && cyc < 40000) begin @(negedge clk); cyc++; end
    chk(done == 1'b1, {req, " done reached"}, int'(done), 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(done == 0 && busy == 0, "R12 done/busy", int'({done, busy}), 0);
    chk(cmd_valid == 0 && test_start == 0, "R12 cmd/test idle", int'({cmd_valid, test_start}), 0);
    chk(inj_count == 0, "R12 count", int'(inj_count), 0);
  endtask

  task automatic t_seq;
    int f, r1, ra, t;
    launch(2'd0, 2'd2, 5, 9, 0, 0, 0);
    wait_done("R11 seq exhaust");
    count_kinds(f, r1, ra, t);
    chk(f == 5 && n_ev == 15, "R11 seq flips", f, 5);
    chk(inj_count == 5, "R10 seq count", int'(inj_count), 5);
    for (int i = 0; i < 5; i++) begin
      chk(ev_kind[3*i] == 0 && ev_addr[3*i] == 5 + i, "R1 seq address", ev_addr[3*i], 5 + i);
      chk(ev_kind[3*i+1] == 3, "R8 test after flip", ev_kind[3*i+1], 3);
      chk(ev_kind[3*i+2] == 1 && ev_addr[3*i+2] == 5 + i, "R2 restore same frame",
          ev_addr[3*i+2], 5 + i);
    end
  endtask

  task automatic t_seq_fail;
    int f, r1, ra, t;
    launch(2'd0, 2'd0, 10, 40, 0, 0, 3);
    wait_done("R6 fail stop");
    count_kinds(f, r1, ra, t);
    chk(f == 3, "R6 flips before stop", f, 3);
    chk(inj_count == 3, "R6 count", int'(inj_count), 3);
    chk(r1 == 3, "R2 restore after failing test", r1, 3);
  endtask

  task automatic t_accum;
    int f, r1, ra, t;
    bit inr;
    launch(2'd1, 2'd1, 100, 130, 0, 20, 2);
    wait_done("R7 budget stop");
    count_kinds(f, r1, ra, t);
    chk(f == 20 && inj_count == 20, "R7 budget ignores fail", f, 20);
    chk(r1 == 0 && ra == 0, "R4 no restore", r1 + ra, 0);
    chk(t == 20, "R8 tests per flip", t, 20);
    inr = 1;
    for (int i = 0; i < n_ev; i++)
      if (ev_kind[i] == 0 && (ev_addr[i] < 100 || ev_addr[i] > 130)) inr = 0;
    chk(inr, "R3 random in window", int'(inr), 1);
  endtask

  task automatic t_cleanup;
    int f, r1, ra, t, seen, k;
    bit inr;
    launch(2'd2, 2'd1, 0, 6, 4, 10, 0);
    wait_done("R5 cleanup run");
    count_kinds(f, r1, ra, t);
    chk(f == 10, "R7 cleanup budget", f, 10);
    chk(ra == 2 && r1 == 0, "R5 restore-all count", ra, 2);
    seen = 0; k = 0; inr = 1;
    for (int i = 0; i < n_ev; i++) begin
      if (ev_kind[i] == 0) begin
        seen++;
        if (ev_addr[i] > 6) inr = 0;
      end
      if (ev_kind[i] == 2) begin
        k++;
        chk(seen == 4 * k, "R5 restore-all position", seen, 4 * k);
        chk(i > 0 && ev_kind[i-1] == 3, "R5 restore-all after test", ev_kind[i-1], 3);
      end
    end
    chk(inr, "R3 rejection keeps window", int'(inr), 1);
  endtask

  task automatic t_clean_zero;
    int f, r1, ra, t;
    launch(2'd2, 2'd1, 20, 50, 0, 3, 0);
    wait_done("R5 zero count");
    count_kinds(f, r1, ra, t);
    chk(ra == 3 && f == 3, "R5 zero behaves as one", ra, 3);
  endtask

  task automatic t_abort;
    int f, r1, ra, t, c;
    int cyc = 0;
    launch(2'd1, 2'd2, 0, 4095, 0, 0, 0);
    while (inj_count < 3 && cyc < 5000) begin @(negedge clk); cyc++; end
    abort = 1'b1;
    c = int'(inj_count);
    @(negedge clk);
    abort = 1'b0;
    wait_done("R7 abort");
    count_kinds(f, r1, ra, t);
    chk(f == int'(inj_count) && (f == c || f == c + 1), "R7 abort stops promptly", f, c);
    chk(t == f, "R7 test completes before stop", t, f);
  endtask

  task automatic t_corners;
    int f, r1, ra, t;
    launch(2'd0, 2'd2, 7, 7, 0, 0, 0);
    wait_done("R11 single address");
    count_kinds(f, r1, ra, t);
    chk(f == 1 && ev_addr[0] == 7, "R11 single-address window", f, 1);
    launch(2'd0, 2'd2, 9, 3, 0, 0, 0);
    wait_done("R11 inverted window");
    chk(n_ev == 0 && inj_count == 0, "R11 inverted window no injection", n_ev, 0);
    chk(cmd_valid == 0 && test_start == 0, "R11 quiet when done", int'(cmd_valid), 0);
  endtask

  task automatic t_protocol;
    chk(!hold_bad, "R9 command held until ready", int'(hold_bad), 0);
    chk(!overlap && !dbl, "R8 no command during test", int'(overlap) + int'(dbl), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_seq;        t_protocol;
    t_seq_fail;   t_protocol;
    t_accum;      t_protocol;
    t_cleanup;    t_protocol;
    t_clean_zero; t_protocol;
    t_abort;      t_protocol;
    t_corners;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule